// File: doc/BRIEF.md
# Block Program/Erase Protection Arbiter

This block sits in front of the program and erase engine of a four-block non-volatile array and decides whether each write-type request may go ahead. Each request carries an 18-bit array address. The upper two bits pick one of four equal blocks. Block 3 is the top block and blocks 0 to 2 are the main blocks. Two active-low hardware protect pins override a per-block lock vector: one covers only the top block and the other covers only the main blocks. When the relevant pin is high, the block's lock bit decides.

A request that is not protected still fails if the programming supply is below its lockout level. That refusal is reported: it sets a sticky error flag, which stays set until a clear-status input is pulsed. A refusal caused by a pin or a lock bit does not set the flag and finishes at once with no array activity. When the arbiter accepts a request it takes a snapshot of the pins, the lock vector, the programming-supply state and the address. It holds that snapshot until the engine signals done.

If the core supply falls below its lockout level, the block leaves whatever it is doing and stops taking requests. An operation in progress is aborted and reported with a one-cycle abort pulse. When the supply recovers, the block returns to the ready (read) state.

The controller has four states. ST_IDLE means ready. ST_DECIDE evaluates the snapshot. ST_ACTIVE waits for op_done. ST_LOCKOUT waits while the core supply is low. The transitions are:
- ST_IDLE to ST_DECIDE on an accepted request.
- ST_DECIDE to ST_ACTIVE on a pass.
- ST_DECIDE to ST_IDLE on a refusal.
- ST_ACTIVE to ST_IDLE on op_done.
- Any state to ST_LOCKOUT when vcc_ok is low.
- ST_LOCKOUT to ST_IDLE when vcc_ok returns.

Top module: `pe_guard`

## Requirements
- R1: The block index is req_addr[17:16]. Index 3 is the top block and indices 0 to 2 are main blocks. op_addr holds the full accepted address while busy is high.
- R2: With top_lock_n low, a request to block 3 is denied whatever its lock bit holds. top_lock_n has no effect on blocks 0 to 2.
- R3: With main_wp_n low, a request to blocks 0 to 2 is denied whatever the lock bits hold. main_wp_n has no effect on block 3.
- R4: With the relevant pin high, lock_bits[b] = 1 denies block b and lock_bits[b] = 0 allows it.
- R5: A request that is not protected but is made with vpp_ok low is denied and sets supply_err. A denial caused by a pin or a lock bit never sets supply_err. When both apply, the protection denial takes precedence.
- R6: supply_err stays set until clr_status is sampled high. If a new supply refusal occurs in the same cycle as the clear, the flag stays set.
- R7: grant or deny is a one-cycle pulse in the second clock cycle after the request edge, and the two are never high together. After a grant, busy is high until the edge on which op_done is sampled.
- R8: Pins, lock bits and vpp_ok are sampled only on the edge that accepts a request. Later changes to them do not alter that decision.
- R9: When vcc_ok is sampled low, an active operation ends with a one-cycle abort_op pulse. The block then stays not ready and ignores requests until vcc_ok is high again, and one cycle later it is ready.
- R10: After reset, ready is 1 and grant, deny, busy, abort_op and supply_err are 0.
- R11: req_valid is ignored while the block is not ready. op_done is ignored unless busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Program/erase request strobe |
| req_addr | input | 18 | Array address of the request |
| top_lock_n | input | 1 | Top-block hardware protect, active low |
| main_wp_n | input | 1 | Main-block hardware protect, active low |
| lock_bits | input | 4 | Per-block lock vector, 1 = locked |
| vpp_ok | input | 1 | Programming supply above lockout |
| vcc_ok | input | 1 | Core supply above lockout |
| op_done | input | 1 | Engine finished the granted operation |
| clr_status | input | 1 | Clears the supply error flag |
| ready | output | 1 | Idle and able to accept a request |
| grant | output | 1 | One-cycle pulse: request allowed |
| deny | output | 1 | One-cycle pulse: request refused |
| busy | output | 1 | Granted operation in progress |
| abort_op | output | 1 | One-cycle pulse: operation aborted by core-supply loss |
| op_addr | output | 18 | Address of the accepted operation |
| supply_err | output | 1 | Sticky programming-supply error flag |

## Verification
A request sampled on edge N moves the block into its decide state. grant or deny, and any new supply_err, are visible after edge N+1. busy rises at that same edge and falls after the edge that samples op_done. abort_op appears after the edge that samples vcc_ok low. The bench keeps a behavioural model that advances on the same rising edges, drives inputs and compares every output on falling edges, so each result is checked in exactly the cycle it is due. Pins are changed one cycle after a request to confirm that the snapshot, not the live pin value, decides the outcome.

// File: rtl/pe_pkg.sv
package pe_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DECIDE,
        ST_ACTIVE,
        ST_LOCKOUT
    } pe_state_t;

    typedef enum logic [1:0] {
        VERD_PASS,
        VERD_PROT,
        VERD_SUPPLY
    } pe_verdict_t;

endpackage

// File: rtl/pe_block_decode.sv
module pe_block_decode #(
    parameter int ADDR_W   = 18,
    parameter int BLK_BITS = 2,
    localparam int NUM_BLK = 1 << BLK_BITS
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_BLK-1:0]  blk_onehot,
    output logic                is_top
);
    localparam int TOP_BLK = NUM_BLK - 1;

    logic [BLK_BITS-1:0] blk_idx;

    // Block index comes from the most significant address bits.
    assign blk_idx = addr[ADDR_W-1 -: BLK_BITS];

    for (genvar g = 0; g < NUM_BLK; g++) begin : g_dec
        assign blk_onehot[g] = (blk_idx == BLK_BITS'(g));
    end

    assign is_top = blk_onehot[TOP_BLK];

endmodule

// File: rtl/pe_prot_eval.sv
module pe_prot_eval
    import pe_pkg::*;
#(
    parameter int NUM_BLK = 4
) (
    input  logic [NUM_BLK-1:0] blk_onehot,
    input  logic               top_pin_n,
    input  logic               main_pin_n,
    input  logic [NUM_BLK-1:0] lock_vec,
    input  logic               vpp_good,
    output pe_verdict_t        verdict
);
    localparam int TOP_BLK = NUM_BLK - 1;

    logic [NUM_BLK-1:0] prot_vec;
    logic               is_prot;

    // Each block is guarded by its own group pin or by its lock bit.
    for (genvar g = 0; g < NUM_BLK; g++) begin : g_prot
        if (g == TOP_BLK) begin : g_top
            assign prot_vec[g] = !top_pin_n || lock_vec[g];
        end else begin : g_main
            assign prot_vec[g] = !main_pin_n || lock_vec[g];
        end
    end

    assign is_prot = |(prot_vec & blk_onehot);

    // Protection refusal wins over supply refusal.
    always_comb begin
        if (is_prot) begin
            verdict = VERD_PROT;
        end else if (!vpp_good) begin
            verdict = VERD_SUPPLY;
        end else begin
            verdict = VERD_PASS;
        end
    end

endmodule

// File: rtl/pe_err_flag.sv
module pe_err_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
        end else if (set_i) begin
            flag_o <= 1'b1;
        end else if (clr_i) begin
            flag_o <= 1'b0;
        end
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o); // R6

endmodule

// File: rtl/pe_guard.sv
module pe_guard
    import pe_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int BLK_BITS = 2,
    localparam int NUM_BLK = 1 << BLK_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic               top_lock_n,
    input  logic               main_wp_n,
    input  logic [NUM_BLK-1:0] lock_bits,
    input  logic               vpp_ok,
    input  logic               vcc_ok,
    input  logic               op_done,
    input  logic               clr_status,
    output logic               ready,
    output logic               grant,
    output logic               deny,
    output logic               busy,
    output logic               abort_op,
    output logic [ADDR_W-1:0]  op_addr,
    output logic               supply_err
);

    pe_state_t   state, nxt_state;
    pe_verdict_t verdict;

    logic [NUM_BLK-1:0] dec_onehot;
    logic               dec_is_top;

    // Snapshot taken on the accepting edge.
    logic [NUM_BLK-1:0] snap_onehot;
    logic               snap_is_top;
    logic               snap_top_pin_n;
    logic               snap_main_pin_n;
    logic [NUM_BLK-1:0] snap_lock;
    logic               snap_vpp_ok;

    logic accept;
    logic err_set;

    pe_block_decode #(
        .ADDR_W   (ADDR_W),
        .BLK_BITS (BLK_BITS)
    ) u_dec (
        .addr       (req_addr),
        .blk_onehot (dec_onehot),
        .is_top     (dec_is_top)
    );

    pe_prot_eval #(
        .NUM_BLK (NUM_BLK)
    ) u_eval (
        .blk_onehot (snap_onehot),
        .top_pin_n  (snap_top_pin_n),
        .main_pin_n (snap_main_pin_n),
        .lock_vec   (snap_lock),
        .vpp_good   (snap_vpp_ok),
        .verdict    (verdict)
    );

    assign accept  = (state == ST_IDLE) && vcc_ok && req_valid;
    assign err_set = (state == ST_DECIDE) && vcc_ok && (verdict == VERD_SUPPLY);

    pe_err_flag u_err (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (err_set),
        .clr_i  (clr_status),
        .flag_o (supply_err)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt_state;
        end
    end

    // Next-state logic
    always_comb begin
        nxt_state = state;
        unique case (state)
            ST_IDLE: begin
                if (!vcc_ok) begin
                    nxt_state = ST_LOCKOUT;
                end else if (req_valid) begin
                    nxt_state = ST_DECIDE;
                end
            end
            ST_DECIDE: begin
                if (!vcc_ok) begin
                    nxt_state = ST_LOCKOUT;
                end else if (verdict == VERD_PASS) begin
                    nxt_state = ST_ACTIVE;
                end else begin
                    nxt_state = ST_IDLE;
                end
            end
            ST_ACTIVE: begin
                if (!vcc_ok) begin
                    nxt_state = ST_LOCKOUT;
                end else if (op_done) begin
                    nxt_state = ST_IDLE;
                end
            end
            ST_LOCKOUT: begin
                if (vcc_ok) begin
                    nxt_state = ST_IDLE;
                end
            end
            default: nxt_state = ST_IDLE;
        endcase
    end

    // Snapshot of pins, locks, supply and address
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_onehot     <= '0;
            snap_is_top     <= 1'b0;
            snap_top_pin_n  <= 1'b0;
            snap_main_pin_n <= 1'b0;
            snap_lock       <= '1;
            snap_vpp_ok     <= 1'b0;
            op_addr         <= '0;
        end else if (accept) begin
            snap_onehot     <= dec_onehot;
            snap_is_top     <= dec_is_top;
            snap_top_pin_n  <= top_lock_n;
            snap_main_pin_n <= main_wp_n;
            snap_lock       <= lock_bits;
            snap_vpp_ok     <= vpp_ok;
            op_addr         <= req_addr;
        end
    end

    // Output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grant    <= 1'b0;
            deny     <= 1'b0;
            abort_op <= 1'b0;
        end else begin
            grant    <= (state == ST_DECIDE) && vcc_ok && (verdict == VERD_PASS);
            deny     <= (state == ST_DECIDE) && vcc_ok && (verdict != VERD_PASS);
            abort_op <= (state == ST_ACTIVE) && !vcc_ok;
        end
    end

    assign ready = (state == ST_IDLE);
    assign busy  = (state == ST_ACTIVE);

    AST_GRANT_DENY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant && deny)); // R7
    AST_TOP_PIN_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> !(snap_is_top && !snap_top_pin_n)); // R2
    AST_MAIN_PIN_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> !(!snap_is_top && !snap_main_pin_n)); // R3
    AST_ERR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(supply_err) |-> (deny && !snap_vpp_ok)); // R5
    AST_ABORT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_op |-> (!busy && $past(!vcc_ok))); // R9
    AST_BUSY_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $past(vcc_ok)); // R9

endmodule

// File: tb/pe_guard_tb_top.sv
module pe_guard_tb_top;
    localparam int AW = 18;
    localparam int NB = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic top_lock_n = 1'b1, main_wp_n = 1'b1;
    logic [NB-1:0] lock_bits = '0;
    logic vpp_ok = 1'b1, vcc_ok = 1'b1, op_done = 1'b0, clr_status = 1'b0;
    logic ready, grant, deny, busy, abort_op, supply_err;
    logic [AW-1:0] op_addr;

    pe_guard #(.ADDR_W(AW), .BLK_BITS(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .top_lock_n(top_lock_n), .main_wp_n(main_wp_n), .lock_bits(lock_bits),
        .vpp_ok(vpp_ok), .vcc_ok(vcc_ok), .op_done(op_done), .clr_status(clr_status),
        .ready(ready), .grant(grant), .deny(deny), .busy(busy), .abort_op(abort_op),
        .op_addr(op_addr), .supply_err(supply_err));

    // Behavioural reference model: 0 idle, 1 decide, 2 active, 3 lockout
    int m_st;
    logic m_grant, m_deny, m_abort, m_err;
    logic [AW-1:0] m_addr;
    logic l_tl, l_wp, l_vpp;
    logic [NB-1:0] l_lk;
    int blk;
    bit prot, sete;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_grant = 0; m_deny = 0; m_abort = 0; m_err = 0; m_addr = '0;
        end else begin
            m_grant = 0; m_deny = 0; m_abort = 0; sete = 0;
            case (m_st)
                0: if (!vcc_ok) m_st = 3;
                   else if (req_valid) begin
                       m_addr = req_addr; l_tl = top_lock_n; l_wp = main_wp_n;
                       l_lk = lock_bits; l_vpp = vpp_ok; m_st = 1;
                   end
                1: if (!vcc_ok) m_st = 3;
                   else begin
                       blk = int'(m_addr[17:16]);
                       prot = (blk == 3) ? (!l_tl || l_lk[blk]) : (!l_wp || l_lk[blk]);
                       if (prot) begin m_deny = 1; m_st = 0; end
                       else if (!l_vpp) begin m_deny = 1; sete = 1; m_st = 0; end
                       else begin m_grant = 1; m_st = 2; end
                   end
                2: if (!vcc_ok) begin m_abort = 1; m_st = 3; end
                   else if (op_done) m_st = 0;
                default: if (vcc_ok) m_st = 0;
            endcase
            if (sete) m_err = 1;
            else if (clr_status) m_err = 0;
        end
    end

    int vectors = 0, fails = 0;
    string cur_tag = "R10";
    bit finished = 0;

    task automatic cmp(string nm, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", cur_tag, nm, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!finished) begin
            cmp("grant", 32'(grant), 32'(m_grant));
            cmp("deny", 32'(deny), 32'(m_deny));
            cmp("abort_op", 32'(abort_op), 32'(m_abort));
            cmp("supply_err", 32'(supply_err), 32'(m_err));
            cmp("busy", 32'(busy), 32'(m_st == 2));
            cmp("ready", 32'(ready), 32'(m_st == 0));
            if (m_st == 2) cmp("op_addr", 32'(op_addr), 32'(m_addr));
        end
    end

    task automatic req(input logic [AW-1:0] a, input logic tl, input logic wp,
                       input logic [NB-1:0] lk, input logic vp, input string tag);
        cur_tag = tag;
        @(negedge clk);
        req_valid = 1; req_addr = a; top_lock_n = tl; main_wp_n = wp; lock_bits = lk; vpp_ok = vp;
        @(negedge clk);
        req_valid = 0;
        repeat (3) @(negedge clk);
        op_done = 1;
        @(negedge clk);
        op_done = 0;
    endtask

    task automatic pulse_clr(input string tag);
        cur_tag = tag;
        @(negedge clk); clr_status = 1;
        @(negedge clk); clr_status = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cur_tag = "R10";
        cmp("reset ready", 32'(ready), 32'd1);
        cmp("reset busy", 32'(busy), 32'd0);
        cmp("reset err", 32'(supply_err), 32'd0);
        rst_n = 1;
        @(negedge clk);
        // R1 / R4: every block open
        for (int b = 0; b < 4; b++) req({2'(b), 16'h1234 + 16'(b)}, 1, 1, 4'b0000, 1, "R1");
        // R4: lock bits decide when pins are high
        req(18'h1_0040, 1, 1, 4'b0010, 1, "R4");
        req(18'h2_0040, 1, 1, 4'b0010, 1, "R4");
        req(18'h3_FFFF, 1, 1, 4'b1000, 1, "R4");
        // R2: top pin
        req(18'h3_0000, 0, 1, 4'b0000, 1, "R2");
        req(18'h0_0100, 0, 1, 4'b0000, 1, "R2");
        // R3: main write-protect pin
        req(18'h2_0100, 1, 0, 4'b0000, 1, "R3");
        req(18'h3_0100, 1, 0, 4'b0000, 1, "R3");
        // R5: protection first, then supply error
        req(18'h1_0000, 1, 1, 4'b0010, 0, "R5");
        cmp("no err on prot deny", 32'(supply_err), 32'd0);
        req(18'h0_0000, 1, 1, 4'b0000, 0, "R5");
        cmp("err after supply deny", 32'(supply_err), 32'd1);
        // R6: sticky, then clear
        req(18'h0_0010, 1, 1, 4'b0000, 1, "R6");
        cmp("err still set", 32'(supply_err), 32'd1);
        pulse_clr("R6");
        cmp("err cleared", 32'(supply_err), 32'd0);
        // R6: clear coincident with a new supply refusal
        cur_tag = "R6";
        @(negedge clk); req_valid = 1; req_addr = 18'h1_0000; lock_bits = 0;
        top_lock_n = 1; main_wp_n = 1; vpp_ok = 0;
        @(negedge clk); req_valid = 0; clr_status = 1;
        @(negedge clk); clr_status = 0;
        cmp("set beats clear", 32'(supply_err), 32'd1);
        pulse_clr("R6");
        // R8: pins change right after acceptance
        cur_tag = "R8";
        @(negedge clk); req_valid = 1; req_addr = 18'h3_0200; top_lock_n = 1; lock_bits = 0; vpp_ok = 1;
        @(negedge clk); req_valid = 0; top_lock_n = 0; lock_bits = 4'hF; vpp_ok = 0;
        @(negedge clk);
        cmp("grant from snapshot", 32'(grant), 32'd1);
        repeat (2) @(negedge clk); op_done = 1;
        @(negedge clk); op_done = 0; top_lock_n = 1; lock_bits = 0; vpp_ok = 1;
        // R11: request while busy, op_done while idle
        cur_tag = "R11";
        @(negedge clk); req_valid = 1; req_addr = 18'h0_0300;
        @(negedge clk); req_valid = 0;
        @(negedge clk); req_valid = 1; req_addr = 18'h1_0000;
        @(negedge clk); req_valid = 0;
        repeat (2) @(negedge clk); op_done = 1;
        @(negedge clk); op_done = 0;
        repeat (2) @(negedge clk); op_done = 1;
        @(negedge clk); op_done = 0;
        // R9: core supply loss during an active op
        cur_tag = "R9";
        @(negedge clk); req_valid = 1; req_addr = 18'h2_0000;
        @(negedge clk); req_valid = 0;
        repeat (2) @(negedge clk); vcc_ok = 0;
        @(negedge clk);
        cmp("abort pulse", 32'(abort_op), 32'd1);
        req_valid = 1;
        repeat (2) @(negedge clk);
        req_valid = 0; vcc_ok = 1;
        @(negedge clk);
        cmp("ready after recovery", 32'(ready), 32'd1);
        // R7: random traffic
        cur_tag = "R7";
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            req_valid = ($urandom % 3) == 0;
            req_addr = AW'($urandom);
            top_lock_n = ($urandom % 4) != 0;
            main_wp_n = ($urandom % 4) != 0;
            lock_bits = NB'($urandom);
            vpp_ok = ($urandom % 5) != 0;
            vcc_ok = ($urandom % 25) != 0;
            op_done = ($urandom % 3) == 0;
            clr_status = ($urandom % 10) == 0;
        end
        @(negedge clk);
        req_valid = 0; op_done = 0; clr_status = 0; vcc_ok = 1;
        repeat (3) @(negedge clk);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            fails++;
            $display("FAIL watchdog %s actual=hung expected=done", cur_tag);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule